// File: doc/BRIEF.md
# Programmable External Bus Timing Sequencer

This block runs one asynchronous access to an external memory at a time. A host issues a read or write request on a valid/ready port. When the request is accepted, the block takes a snapshot of a set of timing values. It then walks a cycle counter from zero and derives every memory-side strobe from that counter: chip select, address valid, write enable, output enable and a read-data capture strobe. Each strobe is active while the counter lies inside its own programmed window.

Chip select and address valid each have separate end points for reads and for writes. Reads and writes also have separate total lengths. The device data bus can be 8 or 16 bits wide. A multiplexed mode puts the low address bits on the shared data lines while address valid is active. An active wait input freezes the counter, which stretches the access. A read completes with a one-cycle done pulse that carries the captured data.

Top module: `ebus_seq`

## Requirements
- R1: Out of reset, and whenever no access is in progress, req_ready_o is 1. All active-low strobes are 1, mem_capture_o and mem_ad_oe_o are 0, and rsp_done_o is 0.
- R2: During an access with counter value c, chip select (mem_cs_n_o low) is active exactly when cs_on <= c < cs_rd_off on a read, or cs_on <= c < cs_wr_off on a write.
- R3: Address valid (mem_adv_n_o low) is active exactly when adv_on <= c < adv_rd_off on a read, or adv_on <= c < adv_wr_off on a write.
- R4: Write enable is active only on writes, for we_on <= c < we_off. Output enable is active only on reads, for oe_on <= c < oe_off.
- R5: A window whose end value is less than or equal to its start value never activates its strobe during that access.
- R6: On a read, mem_capture_o is 1 while c equals the access value, and mem_ad_i is captured then. If the access value is never reached, the returned data is 0.
- R7: A read occupies counter values 0 to rd_cycle-1 and a write occupies 0 to wr_cycle-1, with a length of 0 treated as 1. The first counter value appears in the cycle after acceptance, and req_ready_o is 0 for the whole access.
- R8: In the cycle after a read ends, rsp_done_o is 1 for exactly one cycle and rsp_rdata_o holds the captured data. A write produces no done pulse.
- R9: While mem_wait_i is 1 during an access, the counter holds and the access does not end.
- R10: When tm_wide_i is 0, only mem_ad_i[7:0] is captured and only req_wdata_i[7:0] is driven. Bits 15:8 read and drive as 0. When tm_wide_i is 1, all 16 bits are used.
- R11: On a write, the bus is driven with write data (mem_ad_oe_o 1) from c >= wr_access until the access ends. When tm_mux_i is 1 and write data is not being driven, the low address bits are driven on mem_ad_o while address valid is active.
- R12: Timing inputs are sampled when the request is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | Read completion pulse |
| rsp_rdata_o | output | 16 | Captured read data |
| tm_cs_on_i | input | 8 | Chip select start |
| tm_cs_rd_off_i | input | 8 | Chip select end, reads |
| tm_cs_wr_off_i | input | 8 | Chip select end, writes |
| tm_adv_on_i | input | 8 | Address valid start |
| tm_adv_rd_off_i | input | 8 | Address valid end, reads |
| tm_adv_wr_off_i | input | 8 | Address valid end, writes |
| tm_we_on_i | input | 8 | Write enable start |
| tm_we_off_i | input | 8 | Write enable end |
| tm_oe_on_i | input | 8 | Output enable start |
| tm_oe_off_i | input | 8 | Output enable end |
| tm_access_i | input | 8 | Read data capture point |
| tm_wr_access_i | input | 8 | Write data drive start |
| tm_rd_cycle_i | input | 8 | Read length |
| tm_wr_cycle_i | input | 8 | Write length |
| tm_wide_i | input | 1 | 1 = 16-bit device, 0 = 8-bit |
| tm_mux_i | input | 1 | Address shares data lines |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_adv_n_o | output | 1 | Address valid, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_capture_o | output | 1 | Read data capture strobe |
| mem_addr_o | output | 16 | Address lines |
| mem_ad_o | output | 16 | Data bus, outbound |
| mem_ad_oe_o | output | 1 | Data bus drive enable |
| mem_ad_i | input | 16 | Data bus, inbound |
| mem_wait_i | input | 1 | Wait, holds the counter |

## Verification
Directed accesses are compared cycle by cycle against a window model of every strobe. Reads and writes use deliberately different chip-select and address-valid end points, so a swapped read/write selection shows up as a mismatch. Separate runs cover the following cases, each of which exposes a different class of counter or datapath fault:
- narrow and wide data
- multiplexed and plain address
- empty and zero-length windows
- a wait held in the middle of an access and another held on its last count
- timing inputs changed after acceptance

Off-by-one errors at window edges, errors in lane masking, a counter that ignores the wait input, and timing that is not snapshotted at acceptance each produce a distinct mismatch.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;
  localparam int unsigned TW   = 8;
  localparam int unsigned NSTB = 4;
  localparam int unsigned ST_CS  = 0;
  localparam int unsigned ST_ADV = 1;
  localparam int unsigned ST_WE  = 2;
  localparam int unsigned ST_OE  = 3;

  typedef struct packed {
    logic [TW-1:0] cs_on;
    logic [TW-1:0] cs_rd_off;
    logic [TW-1:0] cs_wr_off;
    logic [TW-1:0] adv_on;
    logic [TW-1:0] adv_rd_off;
    logic [TW-1:0] adv_wr_off;
    logic [TW-1:0] we_on;
    logic [TW-1:0] we_off;
    logic [TW-1:0] oe_on;
    logic [TW-1:0] oe_off;
    logic [TW-1:0] access;
    logic [TW-1:0] wr_access;
    logic [TW-1:0] rd_cycle;
    logic [TW-1:0] wr_cycle;
    logic          wide;
    logic          mux;
  } ebus_tim_t;
endpackage

// File: rtl/ebus_strobe.sv
`timescale 1ns/1ps
module ebus_strobe #(
  parameter int unsigned TW = 8
) (
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] off_i,
  input  logic          en_i,
  output logic          act_o
);
  // half-open window [on, off)
  assign act_o = en_i && (cnt_i >= on_i) && (cnt_i < off_i);
endmodule

// File: rtl/ebus_ctrl.sv
`timescale 1ns/1ps
module ebus_ctrl import ebus_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_we_i,
  input  ebus_tim_t       tim_i,
  input  logic            wait_i,
  output logic            ready_o,
  output logic            start_o,
  output logic            busy_o,
  output logic            we_o,
  output logic [TW-1:0]   cnt_o,
  output ebus_tim_t       tim_o,
  output logic            done_o
);
  logic          busy_q, we_q, done_q;
  logic [TW-1:0] cnt_q, len_raw, len_m1;
  ebus_tim_t     tim_q;
  logic          accept, last;

  assign accept  = req_valid_i && !busy_q;
  assign len_raw = we_q ? tim_q.wr_cycle : tim_q.rd_cycle;
  assign len_m1  = (len_raw == '0) ? '0 : len_raw - 1'b1;
  assign last    = busy_q && !wait_i && (cnt_q == len_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      cnt_q  <= '0;
      tim_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last && !we_q;
      if (accept) begin
        busy_q <= 1'b1;
        we_q   <= req_we_i;
        cnt_q  <= '0;
        tim_q  <= tim_i;
      end else if (busy_q && !wait_i) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o = !busy_q;
  assign start_o = accept;
  assign busy_o  = busy_q;
  assign we_o    = we_q;
  assign cnt_o   = cnt_q;
  assign tim_o   = tim_q;
  assign done_o  = done_q;

  p_wait_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && wait_i |=> busy_q && $stable(cnt_q));
  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= len_m1);
  p_done_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && !we_q);
  p_snapshot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !accept |=> $stable(tim_q));
endmodule

// File: rtl/ebus_dpath.sv
`timescale 1ns/1ps
module ebus_dpath #(
  parameter int unsigned TW = 8,
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  input  logic          we_i,
  input  logic          wide_i,
  input  logic          mux_i,
  input  logic          adv_act_i,
  input  logic [TW-1:0] cnt_i,
  input  logic [TW-1:0] access_i,
  input  logic [TW-1:0] wr_access_i,
  input  logic [DW-1:0] ad_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          capture_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned HW = DW / 2;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          drive_data, drive_addr;

  function automatic logic [DW-1:0] lane_fmt(input logic w, input logic [DW-1:0] d);
    return w ? d : {{(DW-HW){1'b0}}, d[HW-1:0]};
  endfunction

  assign capture_o  = busy_i && !we_i && (cnt_i == access_i);
  assign drive_data = busy_i && we_i && (cnt_i >= wr_access_i);
  assign drive_addr = busy_i && mux_i && adv_act_i && !drive_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else if (start_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      rdata_q <= '0;
    end else if (capture_o) begin
      rdata_q <= lane_fmt(wide_i, ad_i);
    end
  end

  always_comb begin
    ad_o = '0;
    if (drive_data)      ad_o = lane_fmt(wide_i, wdata_q);
    else if (drive_addr) ad_o = addr_q[DW-1:0];
  end

  assign ad_oe_o = drive_data || drive_addr;
  assign addr_o  = addr_q;
  assign rdata_o = rdata_q;

  p_narrow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !wide_i |-> rdata_q[DW-1:HW] == '0);
  p_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o && !mux_i |-> we_i);
  p_capture_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> !we_i);
endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq import ebus_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_done_o,
  output logic [DW-1:0] rsp_rdata_o,
  input  logic [TW-1:0] tm_cs_on_i,
  input  logic [TW-1:0] tm_cs_rd_off_i,
  input  logic [TW-1:0] tm_cs_wr_off_i,
  input  logic [TW-1:0] tm_adv_on_i,
  input  logic [TW-1:0] tm_adv_rd_off_i,
  input  logic [TW-1:0] tm_adv_wr_off_i,
  input  logic [TW-1:0] tm_we_on_i,
  input  logic [TW-1:0] tm_we_off_i,
  input  logic [TW-1:0] tm_oe_on_i,
  input  logic [TW-1:0] tm_oe_off_i,
  input  logic [TW-1:0] tm_access_i,
  input  logic [TW-1:0] tm_wr_access_i,
  input  logic [TW-1:0] tm_rd_cycle_i,
  input  logic [TW-1:0] tm_wr_cycle_i,
  input  logic          tm_wide_i,
  input  logic          tm_mux_i,
  output logic          mem_cs_n_o,
  output logic          mem_adv_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic          mem_capture_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_ad_o,
  output logic          mem_ad_oe_o,
  input  logic [DW-1:0] mem_ad_i,
  input  logic          mem_wait_i
);
  ebus_tim_t     tim_in, tim_q;
  logic          start, busy, we_q;
  logic [TW-1:0] cnt;
  logic [TW-1:0] on_a  [NSTB];
  logic [TW-1:0] off_a [NSTB];
  logic          en_a  [NSTB];
  logic [NSTB-1:0] act;

  always_comb begin
    tim_in.cs_on      = tm_cs_on_i;
    tim_in.cs_rd_off  = tm_cs_rd_off_i;
    tim_in.cs_wr_off  = tm_cs_wr_off_i;
    tim_in.adv_on     = tm_adv_on_i;
    tim_in.adv_rd_off = tm_adv_rd_off_i;
    tim_in.adv_wr_off = tm_adv_wr_off_i;
    tim_in.we_on      = tm_we_on_i;
    tim_in.we_off     = tm_we_off_i;
    tim_in.oe_on      = tm_oe_on_i;
    tim_in.oe_off     = tm_oe_off_i;
    tim_in.access     = tm_access_i;
    tim_in.wr_access  = tm_wr_access_i;
    tim_in.rd_cycle   = tm_rd_cycle_i;
    tim_in.wr_cycle   = tm_wr_cycle_i;
    tim_in.wide       = tm_wide_i;
    tim_in.mux        = tm_mux_i;
  end

  ebus_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_we_i    (req_we_i),
    .tim_i       (tim_in),
    .wait_i      (mem_wait_i),
    .ready_o     (req_ready_o),
    .start_o     (start),
    .busy_o      (busy),
    .we_o        (we_q),
    .cnt_o       (cnt),
    .tim_o       (tim_q),
    .done_o      (rsp_done_o)
  );

  // per-strobe window select; read/write end points differ for CS and ADV
  always_comb begin
    on_a[ST_CS]   = tim_q.cs_on;
    off_a[ST_CS]  = we_q ? tim_q.cs_wr_off : tim_q.cs_rd_off;
    en_a[ST_CS]   = busy;
    on_a[ST_ADV]  = tim_q.adv_on;
    off_a[ST_ADV] = we_q ? tim_q.adv_wr_off : tim_q.adv_rd_off;
    en_a[ST_ADV]  = busy;
    on_a[ST_WE]   = tim_q.we_on;
    off_a[ST_WE]  = tim_q.we_off;
    en_a[ST_WE]   = busy && we_q;
    on_a[ST_OE]   = tim_q.oe_on;
    off_a[ST_OE]  = tim_q.oe_off;
    en_a[ST_OE]   = busy && !we_q;
  end

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    ebus_strobe #(.TW(TW)) u_stb (
      .cnt_i (cnt),
      .on_i  (on_a[g]),
      .off_i (off_a[g]),
      .en_i  (en_a[g]),
      .act_o (act[g])
    );
  end

  assign mem_cs_n_o  = !act[ST_CS];
  assign mem_adv_n_o = !act[ST_ADV];
  assign mem_we_n_o  = !act[ST_WE];
  assign mem_oe_n_o  = !act[ST_OE];

  ebus_dpath #(.TW(TW), .AW(AW), .DW(DW)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .busy_i      (busy),
    .we_i        (we_q),
    .wide_i      (tim_q.wide),
    .mux_i       (tim_q.mux),
    .adv_act_i   (act[ST_ADV]),
    .cnt_i       (cnt),
    .access_i    (tim_q.access),
    .wr_access_i (tim_q.wr_access),
    .ad_i        (mem_ad_i),
    .addr_o      (mem_addr_o),
    .ad_o        (mem_ad_o),
    .ad_oe_o     (mem_ad_oe_o),
    .capture_o   (mem_capture_o),
    .rdata_o     (rsp_rdata_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_cs_n_o && mem_adv_n_o && mem_we_n_o && mem_oe_n_o
                    && !mem_ad_oe_o && !mem_capture_o);
  p_we_only_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> we_q);
  p_oe_only_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> !we_q);
  p_empty_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && (tim_q.cs_on >= off_a[ST_CS]) |-> mem_cs_n_o);
endmodule

// File: tb/tb_ebus_seq.sv
`timescale 1ns/1ps
module tb_ebus_seq;
  import ebus_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, mem_ad_i = '0;
  logic        mem_wait = 1'b0;
  ebus_tim_t   cfg = '0;
  logic        req_ready, rsp_done, cs_n, adv_n, we_n, oe_n, cap, ad_oe;
  logic [15:0] rsp_rdata, mem_addr, mem_ad_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ebus_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .tm_cs_on_i(cfg.cs_on), .tm_cs_rd_off_i(cfg.cs_rd_off), .tm_cs_wr_off_i(cfg.cs_wr_off),
    .tm_adv_on_i(cfg.adv_on), .tm_adv_rd_off_i(cfg.adv_rd_off), .tm_adv_wr_off_i(cfg.adv_wr_off),
    .tm_we_on_i(cfg.we_on), .tm_we_off_i(cfg.we_off),
    .tm_oe_on_i(cfg.oe_on), .tm_oe_off_i(cfg.oe_off),
    .tm_access_i(cfg.access), .tm_wr_access_i(cfg.wr_access),
    .tm_rd_cycle_i(cfg.rd_cycle), .tm_wr_cycle_i(cfg.wr_cycle),
    .tm_wide_i(cfg.wide), .tm_mux_i(cfg.mux),
    .mem_cs_n_o(cs_n), .mem_adv_n_o(adv_n), .mem_we_n_o(we_n), .mem_oe_n_o(oe_n),
    .mem_capture_o(cap), .mem_addr_o(mem_addr), .mem_ad_o(mem_ad_o),
    .mem_ad_oe_o(ad_oe), .mem_ad_i(mem_ad_i), .mem_wait_i(mem_wait)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit win(input int c, input logic [7:0] on, input logic [7:0] off);
    return (c >= int'(on)) && (c < int'(off));
  endfunction

  function automatic logic [15:0] lane(input logic w, input logic [15:0] d);
    return w ? d : {8'h00, d[7:0]};
  endfunction

  // one access, every cycle compared with the window model
  task automatic do_access(input bit we, input logic [15:0] addr, input logic [15:0] wdata,
                           input logic [15:0] bus, input int wait_at, input int wait_len,
                           input bit scramble, input string tag);
    ebus_tim_t t;
    ebus_tim_t saved;
    int c, held, len;
    bit fin;
    logic [6:0] exp_v, act_v;
    logic [15:0] exp_rd;
    t = cfg;
    saved = cfg;
    len = we ? int'(t.wr_cycle) : int'(t.rd_cycle);
    if (len == 0) len = 1;
    @(negedge clk);
    check({tag, " R1 ready before"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wdata; mem_ad_i = bus;
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      // R12: new values after acceptance must not matter
      cfg.cs_on = 8'd0; cfg.cs_rd_off = 8'd1; cfg.oe_on = 8'd0; cfg.oe_off = 8'd1;
      cfg.adv_on = 8'd0; cfg.adv_rd_off = 8'd1; cfg.access = 8'd0; cfg.rd_cycle = 8'd2;
      cfg.wide = ~cfg.wide;
    end
    c = 0; held = 0; fin = 0;
    while (!fin) begin
      exp_v = {1'b0,
               win(c, t.cs_on, we ? t.cs_wr_off : t.cs_rd_off),
               win(c, t.adv_on, we ? t.adv_wr_off : t.adv_rd_off),
               we && win(c, t.we_on, t.we_off),
               !we && win(c, t.oe_on, t.oe_off),
               !we && (c == int'(t.access)),
               1'b0};
      if (we && c >= int'(t.wr_access)) exp_v[0] = 1'b1;
      else if (t.mux && exp_v[4]) exp_v[0] = 1'b1;
      act_v = {req_ready, !cs_n, !adv_n, !we_n, !oe_n, cap, ad_oe};
      check({tag, " R2 R3 R4 R6 R7 strobes"}, 32'(act_v), 32'(exp_v));
      if (exp_v[0]) begin
        if (we && c >= int'(t.wr_access))
          check({tag, " R11 R10 bus data"}, 32'(mem_ad_o), 32'(lane(t.wide, wdata)));
        else
          check({tag, " R11 bus addr"}, 32'(mem_ad_o), 32'(addr));
      end
      if (c == wait_at && held < wait_len) begin
        mem_wait = 1'b1; held++;
      end else begin
        mem_wait = 1'b0;
        if (c == len - 1) fin = 1; else c++;
      end
      @(negedge clk);
    end
    mem_wait = 1'b0;
    check({tag, " R7 R1 idle after"}, 32'({req_ready, cs_n, adv_n, we_n, oe_n, cap, ad_oe}),
          32'(7'b1111100));
    check({tag, " R8 done pulse"}, 32'(rsp_done), 32'(!we));
    if (!we) begin
      exp_rd = (int'(t.access) < len) ? lane(t.wide, bus) : 16'h0000;
      check({tag, " R6 R10 rdata"}, 32'(rsp_rdata), 32'(exp_rd));
    end
    @(negedge clk);
    check({tag, " R8 done one cycle"}, 32'(rsp_done), 32'd0);
    if (scramble) cfg = saved;
  endtask

  task automatic base_cfg();
    cfg = '0;
    cfg.cs_on = 8'd0; cfg.cs_rd_off = 8'd11; cfg.cs_wr_off = 8'd9;
    cfg.adv_on = 8'd1; cfg.adv_rd_off = 8'd4; cfg.adv_wr_off = 8'd6;
    cfg.we_on = 8'd2; cfg.we_off = 8'd7;
    cfg.oe_on = 8'd3; cfg.oe_off = 8'd10;
    cfg.access = 8'd8; cfg.wr_access = 8'd1;
    cfg.rd_cycle = 8'd12; cfg.wr_cycle = 8'd10;
    cfg.wide = 1'b1; cfg.mux = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset strobes", 32'({cs_n, adv_n, we_n, oe_n, cap, ad_oe}), 32'(6'b111100));
    check("R1 reset ready", 32'(req_ready), 32'd1);
    check("R1 reset done", 32'(rsp_done), 32'd0);
  endtask

  task automatic t_basic();
    base_cfg();
    do_access(1'b0, 16'h1234, 16'h0, 16'hBEEF, -1, 0, 1'b0, "read_wide");
    do_access(1'b1, 16'h2345, 16'hA5C3, 16'h0, -1, 0, 1'b0, "write_wide");
  endtask

  task automatic t_narrow();
    base_cfg(); cfg.wide = 1'b0;
    do_access(1'b0, 16'h0042, 16'h0, 16'hC37E, -1, 0, 1'b0, "read_narrow R10");
    do_access(1'b1, 16'h0043, 16'h9A5B, 16'h0, -1, 0, 1'b0, "write_narrow R10");
  endtask

  task automatic t_empty();
    base_cfg();
    cfg.oe_on = 8'd6; cfg.oe_off = 8'd3; cfg.cs_on = 8'd5; cfg.cs_rd_off = 8'd5;
    do_access(1'b0, 16'h0100, 16'h0, 16'h1111, -1, 0, 1'b0, "read_empty R5");
    cfg.we_on = 8'd4; cfg.we_off = 8'd4;
    do_access(1'b1, 16'h0101, 16'h2222, 16'h0, -1, 0, 1'b0, "write_empty R5");
  endtask

  task automatic t_zero();
    cfg = '0;
    do_access(1'b0, 16'h0200, 16'h0, 16'h3333, -1, 0, 1'b0, "read_zero R7");
    do_access(1'b1, 16'h0201, 16'h4444, 16'h0, -1, 0, 1'b0, "write_zero R7");
    base_cfg(); cfg.access = 8'd20;
    do_access(1'b0, 16'h0202, 16'h0, 16'h5555, -1, 0, 1'b0, "read_nocap R6");
  endtask

  task automatic t_wait();
    base_cfg();
    do_access(1'b0, 16'h0300, 16'h0, 16'h6789, 3, 4, 1'b0, "read_wait_mid R9");
    do_access(1'b1, 16'h0301, 16'h789A, 16'h0, 9, 3, 1'b0, "write_wait_last R9");
  endtask

  task automatic t_mux();
    base_cfg(); cfg.mux = 1'b1; cfg.wr_access = 8'd4;
    do_access(1'b1, 16'hCAFE, 16'h1357, 16'h0, -1, 0, 1'b0, "write_mux R11");
    do_access(1'b0, 16'hF00D, 16'h0, 16'h2468, -1, 0, 1'b0, "read_mux R11");
  endtask

  task automatic t_snapshot();
    base_cfg();
    do_access(1'b0, 16'h0400, 16'h0, 16'hABCD, -1, 0, 1'b1, "read_snapshot R12");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_narrow();
    t_empty();
    t_zero();
    t_wait();
    t_mux();
    t_snapshot();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule